// File: doc/BRIEF.md
# Low-Power Mode Entry/Wake Controller

This block sequences a microcontroller core in and out of its two idle modes. Software asks for idle by writing 1 to an idle-request bit. With the write it picks either a light idle, where only the CPU stops, or a deep idle, where every peripheral clock is also gated off and only the time-base timer keeps ticking. The request is checked in the cycle of the write. If an enabled interrupt latch is already set, or a watchdog interrupt is arriving, the request is refused and the core keeps running.

While idle, the block watches the interrupt latches masked by their per-source enables. When any enabled latch is set, it drops the idle bit and returns to the run speed that was in effect before entry. It also raises one of two one-cycle wake actions, chosen by the master interrupt enable. With the master enable at 0 the core resumes at the next instruction and no interrupt is taken. With it at 1 the core services the interrupt first. The block never clears a latch; that is left to software.

A block reset, or any of three reset sources (pin, power-on, voltage detect), sends the block into a warm-up period of a parameterised length. The CPU stays halted during warm-up, and the block then always starts in the normal-speed run mode.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst` is released, `op_mode` reads 4 (warm-up), `cpu_halt` is 1 and `clk_en` is 3'b000 for exactly WARM_CYCLES cycles; after that, `op_mode` reads 0 (normal speed) and `cpu_halt` is 0.
- R2: In a run mode (`op_mode` 0 or 1), a cycle with `wr_idle`=1 and `wr_data`=1, no enabled latch set and `wdt_irq`=0 makes the next cycle show `idle_bit`=1 and `cpu_halt`=1. `op_mode` reads 2 if `wr_deep` was 0, or 3 if `wr_deep` was 1.
- R3: The idle request is refused, with `idle_bit` and `cpu_halt` staying 0, when `irq_latch & irq_en` is nonzero or `wdt_irq` is 1 in the write cycle. A set latch whose enable is 0 does not block entry.
- R4: In either idle mode, a nonzero `irq_latch & irq_en` makes the next cycle show `idle_bit`=0 and `cpu_halt`=0, with `op_mode` back at the pre-entry speed (0 or 1). A set latch whose enable is 0 does not wake the block.
- R5: A wake with `imf`=0 gives a one-cycle `wake_resume`=1 in the first cycle after the wake, with `wake_service`=0.
- R6: A wake with `imf`=1 gives a one-cycle `wake_service`=1 in the first cycle after the wake, with `wake_resume`=0.
- R7: `clk_en` bit 0 is the CPU clock, bit 1 the peripheral clock and bit 2 the time-base timer clock. Its value is 3'b111 in run modes, 3'b110 in light idle, 3'b100 in deep idle and 3'b000 in warm-up.
- R8: Any bit of `rst_src` high at a clock edge, in any mode, puts the block into warm-up (`op_mode` 4, `idle_bit` 0) in the next cycle. Warm-up then lasts WARM_CYCLES cycles after the last such edge and always ends in normal speed (0), even if slow speed was selected before.
- R9: In a run mode, `wr_speed` sets `op_mode` to 1 (`speed_val`=1) or 0 (`speed_val`=0) in the next cycle, and that speed is restored on an interrupt wake.
- R10: A write with `wr_idle`=1 and `wr_data`=0 leaves the block in its run mode with `idle_bit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_src | input | 3 | Reset sources: pin, power-on, voltage detect |
| wr_idle | input | 1 | CPU write strobe to the idle-request bit |
| wr_data | input | 1 | Value written to the idle-request bit |
| wr_deep | input | 1 | Idle depth with the write: 0 light, 1 deep |
| wr_speed | input | 1 | CPU write strobe to the run-speed select |
| speed_val | input | 1 | Run speed: 0 normal, 1 slow |
| wdt_irq | input | 1 | Watchdog interrupt arriving |
| irq_latch | input | NUM_SRC | Interrupt latches |
| irq_en | input | NUM_SRC | Per-source interrupt enables |
| imf | input | 1 | Master interrupt enable |
| idle_bit | output | 1 | Idle-request bit readback |
| cpu_halt | output | 1 | CPU halted |
| clk_en | output | 3 | Per-domain clock enables {timer, peripheral, CPU} |
| op_mode | output | 3 | Mode: 0 normal, 1 slow, 2 light idle, 3 deep idle, 4 warm-up |
| wake_resume | output | 1 | Pulse: resume at the next instruction without service |
| wake_service | output | 1 | Pulse: service the interrupt, then resume |

## Verification
Entry is tried with a clear latch vector, with an enabled latch already set, with a latch set but its enable off, and with a watchdog interrupt in the write cycle. Together these separate real entry from both refusal causes and show that the enable mask applies. Wake is tried with a disabled latch first and then with an enabled one, under both master-enable settings, to tell the resume pulse from the service pulse. A slow-speed entry followed by a reset-source pulse shows that an interrupt wake restores the prior speed while reset always ends in normal speed.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        M_NORMAL = 3'd0,
        M_SLOW   = 3'd1,
        M_IDLE_L = 3'd2,
        M_IDLE_D = 3'd3,
        M_WARM   = 3'd4
    } op_mode_e;

    localparam int NUM_MODES = 5;
    localparam int NUM_DOMS  = 3;
    localparam int DOM_CPU   = 0;
    localparam int DOM_PERIPH = 1;
    localparam int DOM_TBT   = 2;

    // per domain: bit m set means the domain clock runs in mode m
    typedef logic [NUM_MODES-1:0] mode_mask_t;

    function automatic mode_mask_t dom_mask(input int dom);
        case (dom)
            DOM_CPU:    return 5'b00011;
            DOM_PERIPH: return 5'b00111;
            default:    return 5'b01111;
        endcase
    endfunction

    function automatic op_mode_e speed_mode(input logic slow);
        return slow ? M_SLOW : M_NORMAL;
    endfunction

    function automatic logic is_run(input op_mode_e m);
        return (m == M_NORMAL) || (m == M_SLOW);
    endfunction

    function automatic logic is_idle(input op_mode_e m);
        return (m == M_IDLE_L) || (m == M_IDLE_D);
    endfunction

endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] irq_latch,
    input  logic [NUM_SRC-1:0] irq_en,
    output logic               wake_any
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = irq_latch[i] & irq_en[i];
    end

    assign wake_any = |hit;
endmodule

// File: rtl/lpm_warmup_ctr.sv
module lpm_warmup_ctr #(
    parameter int WARM_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic active,
    output logic done
);
    localparam int CW = $clog2(WARM_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WARM_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (active && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = active && !restart && (cnt_q == LAST);
endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
    import lpm_pkg::*;
(
    input  op_mode_e              mode,
    output logic [NUM_DOMS-1:0]   clk_en
);
    for (genvar d = 0; d < NUM_DOMS; d++) begin : g_dom
        localparam mode_mask_t MASK = dom_mask(d);
        always_comb begin
            clk_en[d] = 1'b0;
            for (int m = 0; m < NUM_MODES; m++) begin
                if (mode == op_mode_e'(m)) clk_en[d] = MASK[m];
            end
        end
    end
endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
    import lpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rst_any,
    input  logic     wr_idle,
    input  logic     wr_data,
    input  logic     wr_deep,
    input  logic     wr_speed,
    input  logic     speed_val,
    input  logic     wdt_irq,
    input  logic     wake_any,
    input  logic     imf,
    input  logic     warm_done,
    output op_mode_e mode,
    output logic     wake_resume,
    output logic     wake_service
);
    op_mode_e mode_q;
    logic     slow_q;
    logic     res_q;
    logic     svc_q;
    logic     entry_ok;

    // entry check uses the latch state of the write cycle itself
    assign entry_ok = wr_idle && wr_data && !wake_any && !wdt_irq;

    always_ff @(posedge clk) begin
        if (rst || rst_any) begin
            mode_q <= M_WARM;
            slow_q <= 1'b0;
            res_q  <= 1'b0;
            svc_q  <= 1'b0;
        end else begin
            res_q <= 1'b0;
            svc_q <= 1'b0;
            case (mode_q)
                M_WARM: begin
                    if (warm_done) mode_q <= M_NORMAL;
                end
                M_NORMAL, M_SLOW: begin
                    if (wr_speed) begin
                        slow_q <= speed_val;
                        mode_q <= speed_mode(speed_val);
                    end
                    if (entry_ok) begin
                        mode_q <= wr_deep ? M_IDLE_D : M_IDLE_L;
                    end
                end
                M_IDLE_L, M_IDLE_D: begin
                    if (wake_any) begin
                        mode_q <= speed_mode(slow_q);
                        if (imf) svc_q <= 1'b1;
                        else     res_q <= 1'b1;
                    end
                end
                default: mode_q <= M_WARM;
            endcase
        end
    end

    assign mode         = mode_q;
    assign wake_resume  = res_q;
    assign wake_service = svc_q;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int WARM_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         rst_src,
    input  logic               wr_idle,
    input  logic               wr_data,
    input  logic               wr_deep,
    input  logic               wr_speed,
    input  logic               speed_val,
    input  logic               wdt_irq,
    input  logic [NUM_SRC-1:0] irq_latch,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               imf,
    output logic               idle_bit,
    output logic               cpu_halt,
    output logic [2:0]         clk_en,
    output logic [2:0]         op_mode,
    output logic               wake_resume,
    output logic               wake_service
);
    logic     wake_any;
    logic     warm_done;
    logic     rst_any;
    op_mode_e mode;

    assign rst_any = |rst_src;

    lpm_wake_detect #(.NUM_SRC(NUM_SRC)) wake_i (
        .irq_latch (irq_latch),
        .irq_en    (irq_en),
        .wake_any  (wake_any)
    );

    lpm_warmup_ctr #(.WARM_CYCLES(WARM_CYCLES)) warm_i (
        .clk     (clk),
        .rst     (rst),
        .restart (rst_any),
        .active  (mode == M_WARM),
        .done    (warm_done)
    );

    lpm_seq_fsm fsm_i (
        .clk          (clk),
        .rst          (rst),
        .rst_any      (rst_any),
        .wr_idle      (wr_idle),
        .wr_data      (wr_data),
        .wr_deep      (wr_deep),
        .wr_speed     (wr_speed),
        .speed_val    (speed_val),
        .wdt_irq      (wdt_irq),
        .wake_any     (wake_any),
        .imf          (imf),
        .warm_done    (warm_done),
        .mode         (mode),
        .wake_resume  (wake_resume),
        .wake_service (wake_service)
    );

    lpm_clk_gate gate_i (
        .mode   (mode),
        .clk_en (clk_en)
    );

    assign op_mode  = mode;
    assign idle_bit = is_idle(mode);
    assign cpu_halt = ~clk_en[DOM_CPU];
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         rst_src,
    input logic               wr_idle,
    input logic               wr_data,
    input logic               wr_deep,
    input logic               wr_speed,
    input logic               speed_val,
    input logic               wdt_irq,
    input logic [NUM_SRC-1:0] irq_latch,
    input logic [NUM_SRC-1:0] irq_en,
    input logic               imf,
    input logic               idle_bit,
    input logic               cpu_halt,
    input logic [2:0]         clk_en,
    input logic [2:0]         op_mode,
    input logic               wake_resume,
    input logic               wake_service
);
    logic pend, in_run, in_idle, src_any;
    assign pend    = |(irq_latch & irq_en);
    assign in_run  = (op_mode == 3'd0) || (op_mode == 3'd1);
    assign in_idle = (op_mode == 3'd2) || (op_mode == 3'd3);
    assign src_any = |rst_src;

    assert_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (in_run && wr_idle && wr_data && !pend && !wdt_irq && !src_any) |=> (idle_bit && cpu_halt));

    assert_refuse_R3: assert property (@(posedge clk) disable iff (rst)
        (in_run && wr_idle && (pend || wdt_irq) && !src_any) |=> (!idle_bit && !cpu_halt));

    assert_wake_R4: assert property (@(posedge clk) disable iff (rst)
        (in_idle && pend && !src_any) |=> (!idle_bit && !cpu_halt));

    assert_resume_R5: assert property (@(posedge clk) disable iff (rst)
        (in_idle && pend && !imf && !src_any) |=> (wake_resume && !wake_service));

    assert_service_R6: assert property (@(posedge clk) disable iff (rst)
        (in_idle && pend && imf && !src_any) |=> (wake_service && !wake_resume));

    assert_deep_gates_R7: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 3'd3) |-> (clk_en == 3'b100));

    assert_src_warm_R8: assert property (@(posedge clk) disable iff (rst)
        src_any |=> (op_mode == 3'd4 && !idle_bit));

    assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(wake_resume && wake_service));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (.*);

// File: tb/lpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_ctrl_tb_top;
    localparam int NSRC = 8;
    localparam int WARM = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic [2:0]      rst_src;
    logic            wr_idle, wr_data, wr_deep, wr_speed, speed_val, wdt_irq, imf;
    logic [NSRC-1:0] irq_latch, irq_en;
    logic            idle_bit, cpu_halt, wake_resume, wake_service;
    logic [2:0]      clk_en, op_mode;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    lpm_ctrl #(.NUM_SRC(NSRC), .WARM_CYCLES(WARM)) dut_i (
        .clk(clk), .rst(rst), .rst_src(rst_src), .wr_idle(wr_idle), .wr_data(wr_data),
        .wr_deep(wr_deep), .wr_speed(wr_speed), .speed_val(speed_val), .wdt_irq(wdt_irq),
        .irq_latch(irq_latch), .irq_en(irq_en), .imf(imf), .idle_bit(idle_bit),
        .cpu_halt(cpu_halt), .clk_en(clk_en), .op_mode(op_mode),
        .wake_resume(wake_resume), .wake_service(wake_service)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_idle(input logic data, input logic deep);
        wr_idle = 1'b1; wr_data = data; wr_deep = deep;
        step();
        wr_idle = 1'b0; wr_data = 1'b0; wr_deep = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        chk("R1", "op_mode in warm-up", int'(op_mode), 4);
        chk("R1", "cpu_halt in warm-up", int'(cpu_halt), 1);
        chk("R7", "clk_en in warm-up", int'(clk_en), 0);
        step(WARM - 1);
        chk("R1", "op_mode at last warm-up cycle", int'(op_mode), 4);
        step();
        chk("R1", "op_mode after warm-up", int'(op_mode), 0);
        chk("R1", "cpu_halt after warm-up", int'(cpu_halt), 0);
        chk("R7", "clk_en in run", int'(clk_en), 7);
    endtask

    task automatic t_light_resume;
        irq_latch = '0; irq_en = '0; imf = 1'b0;
        write_idle(1'b1, 1'b0);
        chk("R2", "idle_bit after light entry", int'(idle_bit), 1);
        chk("R2", "op_mode light", int'(op_mode), 2);
        chk("R7", "clk_en light", int'(clk_en), 6);
        irq_latch = 8'h10;
        step();
        chk("R4", "disabled latch keeps idle", int'(op_mode), 2);
        irq_en = 8'h10;
        step();
        chk("R4", "idle_bit after wake", int'(idle_bit), 0);
        chk("R4", "op_mode after wake", int'(op_mode), 0);
        chk("R5", "wake_resume", int'(wake_resume), 1);
        chk("R5", "wake_service", int'(wake_service), 0);
        step();
        chk("R5", "wake_resume one cycle", int'(wake_resume), 0);
        irq_latch = '0; irq_en = '0;
    endtask

    task automatic t_deep_service;
        imf = 1'b1;
        write_idle(1'b1, 1'b1);
        chk("R2", "op_mode deep", int'(op_mode), 3);
        chk("R7", "clk_en deep", int'(clk_en), 4);
        irq_latch = 8'h01; irq_en = 8'h01;
        step();
        chk("R6", "wake_service", int'(wake_service), 1);
        chk("R6", "wake_resume", int'(wake_resume), 0);
        chk("R4", "cpu_halt after deep wake", int'(cpu_halt), 0);
        step();
        chk("R6", "wake_service one cycle", int'(wake_service), 0);
        irq_latch = '0; irq_en = '0; imf = 1'b0;
    endtask

    task automatic t_refuse;
        irq_latch = 8'h80; irq_en = 8'h80;
        write_idle(1'b1, 1'b0);
        chk("R3", "pending latch refuses entry", int'(idle_bit), 0);
        chk("R3", "cpu_halt refused", int'(cpu_halt), 0);
        irq_latch = '0; irq_en = '0;
        wdt_irq = 1'b1;
        write_idle(1'b1, 1'b1);
        wdt_irq = 1'b0;
        chk("R3", "watchdog refuses entry", int'(op_mode), 0);
        irq_latch = 8'h02; irq_en = 8'h00;
        write_idle(1'b1, 1'b0);
        chk("R3", "disabled latch does not block", int'(idle_bit), 1);
        irq_en = 8'h02;
        step();
        chk("R4", "wake after enabling", int'(idle_bit), 0);
        irq_latch = '0; irq_en = '0;
        step();
    endtask

    task automatic t_write_zero;
        write_idle(1'b0, 1'b1);
        chk("R10", "write of 0 keeps run", int'(op_mode), 0);
        chk("R10", "idle_bit after write 0", int'(idle_bit), 0);
    endtask

    task automatic t_speed_and_source;
        wr_speed = 1'b1; speed_val = 1'b1;
        step();
        wr_speed = 1'b0; speed_val = 1'b0;
        chk("R9", "slow speed selected", int'(op_mode), 1);
        write_idle(1'b1, 1'b0);
        irq_latch = 8'h04; irq_en = 8'h04;
        step();
        chk("R9", "slow speed restored on wake", int'(op_mode), 1);
        irq_latch = '0; irq_en = '0;
        write_idle(1'b1, 1'b1);
        chk("R2", "deep entry from slow", int'(op_mode), 3);
        rst_src = 3'b010;
        step();
        rst_src = 3'b000;
        chk("R8", "reset source enters warm-up", int'(op_mode), 4);
        chk("R8", "idle_bit cleared by reset source", int'(idle_bit), 0);
        step(WARM - 1);
        chk("R8", "still warm-up", int'(op_mode), 4);
        step();
        chk("R8", "normal speed after warm-up", int'(op_mode), 0);
    endtask

    initial begin
        rst = 1'b1; rst_src = '0; wr_idle = 0; wr_data = 0; wr_deep = 0;
        wr_speed = 0; speed_val = 0; wdt_irq = 0; imf = 0;
        irq_latch = '0; irq_en = '0;
        #1;
        t_reset();
        t_light_resume();
        t_deep_service();
        t_refuse();
        t_write_zero();
        t_speed_and_source();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule